// File: doc/BRIEF.md
# Iterative Word Divider with Overflow Reporting

This block divides one 32-bit word by another, as either signed or unsigned numbers, over several clock cycles. A pulse on `start` while the unit is idle captures the operands and the mode inputs. One cycle later, or after the quotient has been built one bit per cycle, `done` pulses and the quotient appears together with the overflow bit, the summary-overflow bit and a four-bit condition field. The outputs then hold until the next division completes.

The operands are converted to magnitudes and divided by a radix-2 restoring loop. The quotient is negated when the operand signs differ. Two cases have no defined result: a zero divisor, and the most negative signed word divided by minus one. The block does not run the loop for these. It finishes at once, returns the fixed value `UNDEF_QUOT` and, when overflow reporting is enabled, raises OV and sets the sticky SO.

Top module: `word_divider`

## Requirements
- R1: With `signed_mode`=0, the quotient is the floor of dividend/divisor, with both operands taken as unsigned 32-bit values.
- R2: With `signed_mode`=1, the operands are two's complement and the quotient is truncated toward zero. It is negative exactly when the operand signs differ and the quotient is nonzero.
- R3: With `ov_en`=1, `ov_out` is 1 and `so_out` is 1 for an undefined case, and `ov_out` is 0 otherwise. `so_out` is `so_in` OR `ov_out`, so a set `so_in` is never cleared.
- R4: A zero divisor, in either mode, still completes and returns `UNDEF_QUOT` (default 0xFFFFFFFF).
- R5: In signed mode, 0x80000000 divided by 0xFFFFFFFF is an undefined case: the quotient is `UNDEF_QUOT` and the flags follow R3. In unsigned mode the same operands give 0 and raise no flag.
- R6: With `ov_en`=0, `ov_out` is 0 and `so_out` equals `so_in`, even for the undefined cases.
- R7: For an undefined case, `done` is high in the cycle after the accepting clock edge. Otherwise `done` is high W+1 (33) cycles after that edge.
- R8: `done` is high for exactly one cycle. `quotient`, `ov_out`, `so_out` and `cond` hold their values after it.
- R9: A `start` that arrives between acceptance and the end of the `done` cycle is ignored, and the current division completes unchanged.
- R10: With `rec_en`=1, `cond` is {LT,GT,EQ,SO} in bits [3:0]. LT, GT and EQ come from a signed compare of the quotient with zero, and SO is a copy of `so_out`. With `rec_en`=0, `cond` is 0000.
- R11: After reset, `done`, `quotient`, `ov_out`, `so_out` and `cond` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests a division; taken only when idle |
| signed_mode | input | 1 | 1: signed division, 0: unsigned |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| ov_en | input | 1 | Enables overflow reporting |
| rec_en | input | 1 | Requests the condition field |
| so_in | input | 1 | Current summary-overflow bit |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result |
| ov_out | output | 1 | Overflow bit |
| so_out | output | 1 | Updated summary-overflow bit |
| cond | output | 4 | {LT,GT,EQ,SO} condition field |

## Verification
The checker records the mode and operands at the edge where `start` meets an idle unit. Its properties assume that `start` is the only route into a new division, and that the held outputs are judged only in the `done` cycle or after it. They also assume that reset is applied before any request. The stimulus drives every input on the falling edge, changes operands only alongside `start`, and raises `start` during a busy period only in the case that tests the ignore rule.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic ov_en;
        logic rec_en;
        logic so_in;
        logic neg_q;
        logic special;
    } div_req_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    function automatic cond_t make_cond(input logic sign_bit, input logic is_zero,
                                        input logic so_bit);
        cond_t c;
        c.lt = sign_bit;
        c.gt = !sign_bit && !is_zero;
        c.eq = is_zero;
        c.so = so_bit;
        return c;
    endfunction

endpackage

// File: rtl/wdiv_operand_prep.sv
module wdiv_operand_prep #(
    parameter int unsigned W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] mag_num,
    output logic [W-1:0] mag_den,
    output logic         negate,
    output logic         den_zero,
    output logic         min_by_neg1
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = '1;

    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg     = signed_mode && num[W-1];
        den_neg     = signed_mode && den[W-1];
        mag_num     = num_neg ? (~num + 1'b1) : num;
        mag_den     = den_neg ? (~den + 1'b1) : den;
        negate      = num_neg ^ den_neg;
        den_zero    = (den == '0);
        min_by_neg1 = signed_mode && (num == MOST_NEG) && (den == ALL_ONES);
    end
endmodule

// File: rtl/wdiv_iter_core.sv
module wdiv_iter_core #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_num,
    input  logic [W-1:0] mag_den,
    output logic [W-1:0] quo_next,
    output logic         last
);
    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] cnt_q;

    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] rem_next;

    always_comb begin
        shifted  = {rem_q, quo_q[W-1]};
        trial    = shifted - {1'b0, den_q};
        fits     = !trial[W];
        rem_next = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_next = {quo_q[W-2:0], fits};
        last     = (cnt_q == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= mag_num;
            den_q <= mag_den;
            cnt_q <= '0;
        end else if (step) begin
            rem_q <= rem_next;
            quo_q <= quo_next;
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdiv_result_flags.sv
module wdiv_result_flags
    import wdiv_pkg::*;
#(
    parameter int unsigned   W          = 32,
    parameter logic [W-1:0]  UNDEF_QUOT = '1
) (
    input  div_req_t     req,
    input  logic [W-1:0] raw_quo,
    output logic [W-1:0] quo,
    output logic         ov,
    output logic         so,
    output cond_t        cond
);
    always_comb begin
        if (req.special) begin
            quo = UNDEF_QUOT;
        end else if (req.neg_q) begin
            quo = ~raw_quo + 1'b1;
        end else begin
            quo = raw_quo;
        end
        ov = req.ov_en && req.special;
        so = req.so_in || ov;
        if (req.rec_en) begin
            cond = make_cond(quo[W-1], quo == '0, so);
        end else begin
            cond = '0;
        end
    end
endmodule

// File: rtl/word_divider.sv
module word_divider
    import wdiv_pkg::*;
#(
    parameter int unsigned  W          = 32,
    parameter logic [W-1:0] UNDEF_QUOT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         ov_en,
    input  logic         rec_en,
    input  logic         so_in,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic         ov_out,
    output logic         so_out,
    output logic [3:0]   cond
);
    div_state_e state_q, state_d;
    div_req_t   cur_req, req_q, sel_req;

    logic         idle;
    logic         accept;
    logic         step;
    logic         fin_load;

    logic [W-1:0] mag_num, mag_den;
    logic         negate, den_zero, min_by_neg1;
    logic [W-1:0] core_quo_next;
    logic         core_last;

    logic [W-1:0] res_quo;
    logic         res_ov, res_so;
    cond_t        res_cond;

    logic [W-1:0] quo_q;
    logic         ov_q, so_q;
    cond_t        cond_q;

    wdiv_operand_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .num         (dividend),
        .den         (divisor),
        .mag_num     (mag_num),
        .mag_den     (mag_den),
        .negate      (negate),
        .den_zero    (den_zero),
        .min_by_neg1 (min_by_neg1)
    );

    always_comb begin
        idle            = (state_q == ST_IDLE);
        accept          = start && idle;
        step            = (state_q == ST_RUN);
        cur_req.ov_en   = ov_en;
        cur_req.rec_en  = rec_en;
        cur_req.so_in   = so_in;
        cur_req.neg_q   = negate;
        cur_req.special = den_zero || min_by_neg1;
        sel_req         = idle ? cur_req : req_q;
        fin_load        = (accept && cur_req.special) || (step && core_last);
    end

    wdiv_iter_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (step),
        .mag_num  (mag_num),
        .mag_den  (mag_den),
        .quo_next (core_quo_next),
        .last     (core_last)
    );

    wdiv_result_flags #(.W(W), .UNDEF_QUOT(UNDEF_QUOT)) u_flags (
        .req     (sel_req),
        .raw_quo (core_quo_next),
        .quo     (res_quo),
        .ov      (res_ov),
        .so      (res_so),
        .cond    (res_cond)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = cur_req.special ? ST_FIN : ST_RUN;
            ST_RUN:  if (core_last) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            quo_q   <= '0;
            ov_q    <= 1'b0;
            so_q    <= 1'b0;
            cond_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q <= cur_req;
            end
            if (fin_load) begin
                quo_q  <= res_quo;
                ov_q   <= res_ov;
                so_q   <= res_so;
                cond_q <= res_cond;
            end
        end
    end

    always_comb begin
        done     = (state_q == ST_FIN);
        quotient = quo_q;
        ov_out   = ov_q;
        so_out   = so_q;
        cond     = cond_q;
    end
endmodule

// File: rtl/wdiv_checker.sv
module wdiv_checker #(
    parameter int unsigned  W          = 32,
    parameter logic [W-1:0] UNDEF_QUOT = '1
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         idle,
    input logic         signed_mode,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         ov_en,
    input logic         rec_en,
    input logic         so_in,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic         ov_out,
    input logic         so_out,
    input logic [3:0]   cond
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic        taken;
    logic        in_zero, in_special;
    logic        cap_zero, cap_special, cap_oe, cap_rec, cap_so;
    logic [31:0] lat_q;

    always_comb begin
        taken      = start && idle;
        in_zero    = (divisor == '0);
        in_special = in_zero ||
                     (signed_mode && dividend == MOST_NEG && divisor == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_zero    <= 1'b0;
            cap_special <= 1'b0;
            cap_oe      <= 1'b0;
            cap_rec     <= 1'b0;
            cap_so      <= 1'b0;
            lat_q       <= '0;
        end else if (taken) begin
            cap_zero    <= in_zero;
            cap_special <= in_special;
            cap_oe      <= ov_en;
            cap_rec     <= rec_en;
            cap_so      <= so_in;
            lat_q       <= 32'd1;
        end else if (lat_q != '1) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R8
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == (cap_special ? 32'd1 : 32'(W + 1))));  // R7
    AST_ZERO_DIV_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (done && cap_zero) |-> (quotient == UNDEF_QUOT));  // R4
    AST_OV_ON_SPECIAL: assert property (@(posedge clk) disable iff (rst)
        (done && cap_special && cap_oe) |-> (ov_out && so_out));  // R3
    AST_OV_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (done && !cap_oe) |-> (!ov_out && (so_out == cap_so)));  // R6
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && cap_so) |-> so_out);  // R3
    AST_COND_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        (done && cap_rec) |-> ($countones(cond[3:1]) == 1));  // R10
    AST_COND_SO_COPY: assert property (@(posedge clk) disable iff (rst)
        (done && cap_rec) |-> (cond[0] == so_out));  // R10
    AST_COND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done && !cap_rec) |-> (cond == 4'b0000));  // R10
    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || ($stable(quotient) && $stable(cond))));  // R8
endmodule

bind word_divider wdiv_checker #(.W(W), .UNDEF_QUOT(UNDEF_QUOT)) u_wdiv_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .idle        (idle),
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .ov_en       (ov_en),
    .rec_en      (rec_en),
    .so_in       (so_in),
    .done        (done),
    .quotient    (quotient),
    .ov_out      (ov_out),
    .so_out      (so_out),
    .cond        (cond)
);

// File: tb/word_divider_bench.sv
module word_divider_bench;
    localparam logic [31:0] UNDEF = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        ov_en = 1'b0;
    logic        rec_en = 1'b0;
    logic        so_in = 1'b0;
    logic        done;
    logic [31:0] quotient;
    logic        ov_out;
    logic        so_out;
    logic [3:0]  cond;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    word_divider u_word_divider (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .ov_en(ov_en), .rec_en(rec_en),
        .so_in(so_in), .done(done), .quotient(quotient), .ov_out(ov_out),
        .so_out(so_out), .cond(cond)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One division; qreq names the requirement behind the quotient value.
    task automatic run_div(input string qreq, input bit sgn, input logic [31:0] a,
                           input logic [31:0] b, input bit oe, input bit rc,
                           input bit so, input bit poke);
        logic [31:0] exp_q;
        logic [3:0]  exp_c;
        bit          special, exp_ov, exp_so;
        int          exp_lat, cyc;
        logic [31:0] held_q;
        special = (b == 0) || (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
        if (special) exp_q = UNDEF;
        else if (sgn) exp_q = $signed(a) / $signed(b);
        else exp_q = a / b;
        exp_ov  = oe && special;
        exp_so  = so || exp_ov;
        exp_c   = rc ? {exp_q[31], !exp_q[31] && exp_q != 0, exp_q == 0, exp_so} : 4'b0;
        exp_lat = special ? 1 : 33;

        @(negedge clk);
        signed_mode = sgn; dividend = a; divisor = b;
        ov_en = oe; rec_en = rc; so_in = so; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            if (poke && cyc == 5) begin
                // R9: new request while busy must be dropped
                start = 1'b1; dividend = a ^ 32'h55; divisor = 32'd3;
                signed_mode = !sgn; ov_en = 1'b1; so_in = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done == 1'b1, "R7", "done seen", 32'(done), 32'd1);
        check(cyc == exp_lat, "R7", "latency", cyc, exp_lat);
        check(quotient == exp_q, qreq, "quotient", quotient, exp_q);
        check(ov_out == exp_ov, oe ? "R3" : "R6", "ov_out", 32'(ov_out), 32'(exp_ov));
        check(so_out == exp_so, oe ? "R3" : "R6", "so_out", 32'(so_out), 32'(exp_so));
        check(cond == exp_c, "R10", "cond", 32'(cond), 32'(exp_c));
        held_q = quotient;
        @(negedge clk);
        check(done == 1'b0, "R8", "done drops", 32'(done), 32'd0);
        check(quotient == held_q, "R8", "quotient held", quotient, held_q);
    endtask

    task automatic t_reset();
        check(done == 0, "R11", "done", 32'(done), 0);
        check(quotient == 0, "R11", "quotient", quotient, 0);
        check(ov_out == 0 && so_out == 0, "R11", "ov/so", {ov_out, so_out}, 0);
        check(cond == 0, "R11", "cond", 32'(cond), 0);
    endtask

    task automatic t_unsigned();  // R1
        run_div("R1", 0, 32'd100, 32'd7, 1, 1, 0, 0);
        run_div("R1", 0, 32'hFFFF_FFFF, 32'd1, 1, 0, 0, 0);
        run_div("R1", 0, 32'd5, 32'd9, 0, 1, 0, 0);
        run_div("R1", 0, 32'hDEAD_BEEF, 32'h0001_0003, 1, 1, 0, 0);
    endtask

    task automatic t_signed();  // R2
        run_div("R2", 1, -32'sd100, 32'sd7, 1, 1, 0, 0);
        run_div("R2", 1, 32'sd100, -32'sd7, 0, 1, 0, 0);
        run_div("R2", 1, -32'sd100, -32'sd7, 1, 1, 0, 0);
        run_div("R2", 1, -32'sd3, 32'sd4, 1, 1, 0, 0);
        run_div("R2", 1, 32'h8000_0000, 32'd2, 1, 1, 0, 0);
    endtask

    task automatic t_zero_div();  // R4 with R3 flags
        run_div("R4", 0, 32'd1234, 32'd0, 1, 1, 0, 0);
        run_div("R4", 1, -32'sd5, 32'd0, 1, 1, 0, 0);
    endtask

    task automatic t_min_neg1();  // R5
        run_div("R5", 1, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0, 0);
        run_div("R5", 0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0, 0);
    endtask

    task automatic t_ov_disabled();  // R6
        run_div("R6", 0, 32'd77, 32'd0, 0, 1, 0, 0);
        run_div("R6", 1, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, 0);
    endtask

    task automatic t_sticky();  // R3: so_in survives a clean division
        run_div("R3", 0, 32'd50, 32'd5, 1, 1, 1, 0);
    endtask

    task automatic t_busy();  // R9
        run_div("R9", 0, 32'd1000, 32'd10, 0, 1, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_zero_div();
        t_min_neg1();
        t_ov_disabled();
        t_sticky();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule